// File: doc/BRIEF.md
# Dual-Width Integer ALU

This block is the execute stage for arithmetic-class instructions. A request carries a 4-bit operation code, a width mode that selects 32-bit or 64-bit operation, the current destination value, the source register value, a 32-bit immediate and a select bit that says which of the two feeds the source operand. The block returns the new destination value. In 32-bit mode both operands are cut to their low halves and the result is zero-extended into the full 64-bit word.

Most operations complete in one cycle through a combinational datapath and a result register. Unsigned division and modulo go to a serial restoring divider. It holds the block busy for a fixed number of cycles and then raises the done pulse. A byte-order operation either truncates the destination to 16, 32 or 64 bits or reverses its bytes within that width. The immediate selects the width.

Top module: `int_alu`

## Requirements
- R1: Operation codes: 0x0 add, 0x1 subtract, 0x2 multiply (low half), 0x4 or, 0x5 and, 0xa xor, 0xb move (result is the source), 0x8 negate (result is minus the destination). In 64-bit mode (wide_i=1) they act on the full 64-bit operands.
- R2: In 32-bit mode (wide_i=0), both operands are reduced to bits 31:0 and every result except codes 0xd, 0xe and 0xf has bits 63:32 cleared.
- R3: With src_sel_i=0 the source is imm_i. It is sign-extended to 64 bits for every code except 0x3 and 0x9, which zero-extend it. With src_sel_i=1 the source is src_i.
- R4: Shifts use the source masked to 5 bits in 32-bit mode and 6 bits in 64-bit mode. Code 0x6 shifts left, 0x7 shifts right logically, and 0xc shifts right arithmetically, replicating bit 31 or bit 63 respectively.
- R5: Code 0x3 gives the unsigned quotient and 0x9 the unsigned remainder. A zero divisor gives a quotient of 0 and a remainder equal to the (width-reduced) destination.
- R6: Code 0xd reorders bytes at a width of imm_i = 16, 32 or 64 and ignores wide_i. With src_sel_i=0 it keeps the low bytes of that width. With src_sel_i=1 it reverses the bytes within that width. Bits above the width are cleared in both cases. Any other imm_i value returns dst_i unchanged.
- R7: Codes 0xe and 0xf return dst_i unchanged in either mode.
- R8: For every code other than 0x3 and 0x9, done_o is high for exactly the one cycle after an accepted start_i, and result_o holds the result in that cycle.
- R9: For codes 0x3 and 0x9, busy_o is high from the cycle after the accepted start_i, and done_o rises XLEN+1 clock edges after the start edge (65 at the default XLEN).
- R10: A start_i that arrives while busy_o is high is ignored. It produces no done_o and does not disturb the division in flight.
- R11: During and directly after reset, busy_o, done_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled with the operand inputs |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| src_sel_i | input | 1 | 1 selects src_i, 0 selects imm_i; for code 0xd, 1 selects byte reversal |
| imm_i | input | 32 | Immediate operand, or the width for code 0xd |
| dst_i | input | XLEN | Destination operand |
| src_i | input | XLEN | Source register operand |
| busy_o | output | 1 | Divider occupied |
| done_o | output | 1 | Result valid pulse |
| result_o | output | XLEN | New destination value |

## Verification
The bench targets the spots where the two widths diverge. A 32-bit add whose carry leaves bit 31 must produce zero; a design that skipped the zero-extension would leave a 1 in bit 32. An immediate of 0xFFFFFFFF is used both as a 64-bit xor/add source, where it must act as minus one, and as a divisor, where it must stay positive. Getting the extension backwards in either case returns a clearly wrong quotient or sum. Division and remainder by zero are exercised, along with a 32-bit remainder whose dividend has bit 31 set, so a signed divider shows up as a wrong remainder. The bench also issues starts during a division in flight: a block that accepted them would pulse done early or overwrite the quotient.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_MUL   = 4'h2,
    OP_DIV   = 4'h3,
    OP_OR    = 4'h4,
    OP_AND   = 4'h5,
    OP_SHL   = 4'h6,
    OP_SHR   = 4'h7,
    OP_NEG   = 4'h8,
    OP_MOD   = 4'h9,
    OP_XOR   = 4'ha,
    OP_MOV   = 4'hb,
    OP_SAR   = 4'hc,
    OP_BORD  = 4'hd,
    OP_RSV_E = 4'he,
    OP_RSV_F = 4'hf
  } alu_op_e;

  function automatic logic is_div_op(input logic [3:0] op);
    return (op == OP_DIV) || (op == OP_MOD);
  endfunction
endpackage

// File: rtl/int_alu_opnd.sv
module int_alu_opnd #(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  logic            wide_i,
  input  logic            src_sel_i,
  input  logic            is_div_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] src_val;

  // divide/modulo treat the immediate as unsigned
  assign imm_ext = {{(XLEN-IMMW){imm_i[IMMW-1] & ~is_div_i}}, imm_i};
  assign src_val = src_sel_i ? src_i : imm_ext;
  assign a_o = wide_i ? dst_i   : {{(XLEN-HALF){1'b0}}, dst_i[HALF-1:0]};
  assign b_o = wide_i ? src_val : {{(XLEN-HALF){1'b0}}, src_val[HALF-1:0]};
endmodule

// File: rtl/int_alu_exec.sv
module int_alu_exec
  import int_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  logic [3:0]      op_i,
  input  logic            wide_i,
  input  logic            to_big_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int HALF  = XLEN / 2;
  localparam int SHW   = $clog2(XLEN);
  localparam int NBYTE = XLEN / 8;

  function automatic logic [XLEN-1:0] rev_bytes(input logic [XLEN-1:0] x, input int nb);
    logic [XLEN-1:0] y;
    y = '0;
    for (int i = 0; i < NBYTE; i++)
      if (i < nb) y[8*i +: 8] = x[8*(nb-1-i) +: 8];
    return y;
  endfunction

  function automatic logic [XLEN-1:0] low_bytes(input logic [XLEN-1:0] x, input int nb);
    logic [XLEN-1:0] y;
    y = '0;
    for (int i = 0; i < NBYTE; i++)
      if (i < nb) y[8*i +: 8] = x[8*i +: 8];
    return y;
  endfunction

  logic [SHW-1:0]  shamt;
  logic [HALF-1:0] sar_half;
  logic [XLEN-1:0] raw;
  logic [XLEN-1:0] bord;
  int              nb;

  assign shamt    = wide_i ? b_i[SHW-1:0] : {1'b0, b_i[SHW-2:0]};
  assign sar_half = $signed(a_i[HALF-1:0]) >>> shamt[SHW-2:0];

  always_comb begin
    case (imm_i)
      IMMW'(16): nb = 2;
      IMMW'(32): nb = 4;
      IMMW'(64): nb = (XLEN >= 64) ? 8 : 0;
      default:   nb = 0;
    endcase
    if (nb == 0)       bord = dst_i;
    else if (to_big_i) bord = rev_bytes(dst_i, nb);
    else               bord = low_bytes(dst_i, nb);
  end

  always_comb begin
    case (op_i)
      OP_ADD:  raw = a_i + b_i;
      OP_SUB:  raw = a_i - b_i;
      OP_MUL:  raw = a_i * b_i;
      OP_OR:   raw = a_i | b_i;
      OP_AND:  raw = a_i & b_i;
      OP_XOR:  raw = a_i ^ b_i;
      OP_MOV:  raw = b_i;
      OP_NEG:  raw = -a_i;
      OP_SHL:  raw = a_i << shamt;
      OP_SHR:  raw = a_i >> shamt;
      OP_SAR:  raw = wide_i ? XLEN'($signed(a_i) >>> shamt)
                            : {{(XLEN-HALF){1'b0}}, sar_half};
      default: raw = dst_i;
    endcase
    if (op_i == OP_BORD)                         res_o = bord;
    else if (op_i == OP_RSV_E || op_i == OP_RSV_F) res_o = dst_i;
    else if (wide_i)                             res_o = raw;
    else                                         res_o = {{(XLEN-HALF){1'b0}}, raw[HALF-1:0]};
  end
endmodule

// File: rtl/int_alu_div.sv
module int_alu_div #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            is_mod_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] res_o
);
  localparam int CW = $clog2(XLEN);

  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, done_q, mod_q;
  logic [XLEN:0]   rem_sh, diff;
  logic            ge;

  assign rem_sh = {rem_q, quo_q[XLEN-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};
  assign ge     = ~diff[XLEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mod_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= a_i;
        dvs_q  <= b_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        mod_q  <= is_mod_i;
      end else if (busy_q) begin
        rem_q <= ge ? diff[XLEN-1:0] : rem_sh[XLEN-1:0];
        quo_q <= {quo_q[XLEN-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(XLEN-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // zero divisor: restoring steps leave rem = dividend, quotient forced to 0
  assign res_o  = mod_q ? rem_q : ((dvs_q == '0) ? '0 : quo_q);
  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r5_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && dvs_q != '0) |-> (rem_q < dvs_q));
  a_r9_done_on_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [3:0]      op_i,
  input  logic            wide_i,
  input  logic            src_sel_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);
  localparam int HALF = XLEN / 2;

  logic            is_div, accept;
  logic [XLEN-1:0] a, b, exec_res, div_res;
  logic            div_busy, div_done;
  logic            sdone_q, wide_q;
  logic [3:0]      op_q;
  logic [IMMW-1:0] imm_q;
  logic [XLEN-1:0] res_q;

  assign is_div = is_div_op(op_i);
  assign accept = start_i && !div_busy;

  int_alu_opnd #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
    .wide_i    (wide_i),
    .src_sel_i (src_sel_i),
    .is_div_i  (is_div),
    .imm_i     (imm_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .a_o       (a),
    .b_o       (b)
  );

  int_alu_exec #(.XLEN(XLEN), .IMMW(IMMW)) u_exec (
    .op_i     (op_i),
    .wide_i   (wide_i),
    .to_big_i (src_sel_i),
    .imm_i    (imm_i),
    .dst_i    (dst_i),
    .a_i      (a),
    .b_i      (b),
    .res_o    (exec_res)
  );

  int_alu_div #(.XLEN(XLEN)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept && is_div),
    .is_mod_i (op_i == OP_MOD),
    .a_i      (a),
    .b_i      (b),
    .busy_o   (div_busy),
    .done_o   (div_done),
    .res_o    (div_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdone_q <= 1'b0;
      res_q   <= '0;
      op_q    <= '0;
      wide_q  <= 1'b0;
      imm_q   <= '0;
    end else begin
      sdone_q <= accept && !is_div;
      if (accept && !is_div) res_q <= exec_res;
      if (accept) begin
        op_q   <= op_i;
        wide_q <= wide_i;
        imm_q  <= imm_i;
      end
    end
  end

  assign busy_o   = div_busy;
  assign done_o   = sdone_q | div_done;
  assign result_o = div_done ? div_res : res_q;

  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_div) |=> done_o);
  a_r9_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_div) |=> (busy_o && !done_o));
  a_r10_quiet_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  a_r2_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_q && op_q < 4'hd) |-> (result_o[XLEN-1:HALF] == '0));
  a_r6_width16_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_BORD && imm_q == IMMW'(16)) |-> (result_o[XLEN-1:16] == '0));
endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int XLEN = 64;
  localparam int NV   = 36;

  typedef struct packed {
    logic [23:0] tag;
    logic [3:0]  op;
    logic        wide;
    logic        sel;
    logic [31:0] imm;
    logic [63:0] dst;
    logic [63:0] src;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{"R1 ", 4'h0, 1'b1, 1'b1, 32'h0, 64'h0000_0001_FFFF_FFFF, 64'h1, 64'h0000_0002_0000_0000},
    '{"R2 ", 4'h0, 1'b0, 1'b1, 32'h0, 64'h0000_0001_FFFF_FFFF, 64'h1, 64'h0},
    '{"R1 ", 4'h1, 1'b1, 1'b1, 32'h0, 64'h5, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE},
    '{"R2 ", 4'h1, 1'b0, 1'b1, 32'h0, 64'h5, 64'h7, 64'h0000_0000_FFFF_FFFE},
    '{"R1 ", 4'h2, 1'b1, 1'b1, 32'h0, 64'h1_0000_0000, 64'h3, 64'h3_0000_0000},
    '{"R2 ", 4'h2, 1'b0, 1'b1, 32'h0, 64'h1_0000_0003, 64'h2_0000_0005, 64'hF},
    '{"R1 ", 4'h4, 1'b1, 1'b1, 32'h0, 64'hF0F0, 64'h0F0F_0000_0000_0000, 64'h0F0F_0000_0000_F0F0},
    '{"R1 ", 4'h5, 1'b1, 1'b1, 32'h0, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0, 64'h1234_0000_9ABC_0000},
    '{"R3 ", 4'ha, 1'b1, 1'b0, 32'h8000_0001, 64'h0, 64'h0, 64'hFFFF_FFFF_8000_0001},
    '{"R2 ", 4'ha, 1'b0, 1'b0, 32'h8000_0001, 64'hFFFF_FFFF_0000_0001, 64'h0, 64'h0000_0000_8000_0000},
    '{"R3 ", 4'hb, 1'b1, 1'b0, 32'hFFFF_FFFF, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
    '{"R1 ", 4'h8, 1'b1, 1'b1, 32'h0, 64'h1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
    '{"R2 ", 4'h8, 1'b0, 1'b1, 32'h0, 64'h1, 64'h0, 64'h0000_0000_FFFF_FFFF},
    '{"R4 ", 4'h6, 1'b1, 1'b1, 32'h0, 64'h1, 64'h41, 64'h2},
    '{"R4 ", 4'h6, 1'b0, 1'b1, 32'h0, 64'h8000_0001, 64'h21, 64'h2},
    '{"R4 ", 4'h7, 1'b1, 1'b1, 32'h0, 64'h8000_0000_0000_0000, 64'h3F, 64'h1},
    '{"R4 ", 4'hc, 1'b1, 1'b1, 32'h0, 64'h8000_0000_0000_0000, 64'h4, 64'hF800_0000_0000_0000},
    '{"R4 ", 4'hc, 1'b0, 1'b1, 32'h0, 64'h0000_0000_8000_0000, 64'h4, 64'h0000_0000_F800_0000},
    '{"R5 ", 4'h3, 1'b1, 1'b1, 32'h0, 64'd100, 64'd7, 64'd14},
    '{"R5 ", 4'h3, 1'b0, 1'b0, 32'hFFFF_FFFF, 64'hFFFF_FFFF, 64'h0, 64'h1},
    '{"R3 ", 4'h3, 1'b1, 1'b0, 32'hFFFF_FFFF, 64'h1_FFFF_FFFE, 64'h0, 64'h2},
    '{"R5 ", 4'h9, 1'b1, 1'b1, 32'h0, 64'd100, 64'd7, 64'd2},
    '{"R5 ", 4'h3, 1'b1, 1'b1, 32'h0, 64'd55, 64'h0, 64'h0},
    '{"R5 ", 4'h9, 1'b1, 1'b1, 32'h0, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h1234_5678_9ABC_DEF0},
    '{"R5 ", 4'h9, 1'b0, 1'b1, 32'h0, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0000_0000_9ABC_DEF0},
    '{"R5 ", 4'h9, 1'b0, 1'b1, 32'h0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd7, 64'd2},
    '{"R6 ", 4'hd, 1'b1, 1'b0, 32'd16, 64'h1122_3344_5566_7788, 64'h0, 64'h7788},
    '{"R6 ", 4'hd, 1'b1, 1'b1, 32'd16, 64'h1122_3344_5566_7788, 64'h0, 64'h8877},
    '{"R6 ", 4'hd, 1'b1, 1'b1, 32'd32, 64'h1122_3344_5566_7788, 64'h0, 64'h8877_6655},
    '{"R6 ", 4'hd, 1'b0, 1'b1, 32'd64, 64'h1122_3344_5566_7788, 64'h0, 64'h8877_6655_4433_2211},
    '{"R6 ", 4'hd, 1'b1, 1'b0, 32'd64, 64'h1122_3344_5566_7788, 64'h0, 64'h1122_3344_5566_7788},
    '{"R6 ", 4'hd, 1'b0, 1'b0, 32'd32, 64'h1122_3344_5566_7788, 64'h0, 64'h5566_7788},
    '{"R6 ", 4'hd, 1'b1, 1'b1, 32'd8, 64'h1122_3344_5566_7788, 64'h0, 64'h1122_3344_5566_7788},
    '{"R7 ", 4'he, 1'b0, 1'b1, 32'h0, 64'hDEAD_BEEF_0000_1111, 64'h5, 64'hDEAD_BEEF_0000_1111},
    '{"R7 ", 4'hf, 1'b1, 1'b1, 32'h0, 64'hDEAD_BEEF_0000_1111, 64'h5, 64'hDEAD_BEEF_0000_1111},
    '{"R3 ", 4'h0, 1'b1, 1'b0, 32'hFFFF_FFFF, 64'd10, 64'h0, 64'd9}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [3:0]      op_i = '0;
  logic            wide_i = 1'b0;
  logic            src_sel_i = 1'b0;
  logic [31:0]     imm_i = '0;
  logic [XLEN-1:0] dst_i = '0;
  logic [XLEN-1:0] src_i = '0;
  logic            busy_o, done_o;
  logic [XLEN-1:0] result_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  int_alu #(.XLEN(XLEN), .IMMW(32)) u_int_alu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_i      (op_i),
    .wide_i    (wide_i),
    .src_sel_i (src_sel_i),
    .imm_i     (imm_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o)
  );

  task automatic check(input logic [23:0] tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic wide, input logic sel,
                        input logic [31:0] imm, input logic [63:0] dst, input logic [63:0] src,
                        output logic [63:0] res, output int lat);
    @(negedge clk_i);
    op_i = op; wide_i = wide; src_sel_i = sel; imm_i = imm; dst_i = dst; src_i = src;
    start_i = 1'b1;
    lat = 0;
    res = '0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o) begin
        res = result_o;
        break;
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r;
    int          lat;
    int          cyc;
    int          ndone;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11", {62'b0, busy_o, done_o}, 64'h0);
    check("R11", result_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11", {62'b0, busy_o, done_o}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].op, VEC[i].wide, VEC[i].sel, VEC[i].imm, VEC[i].dst, VEC[i].src, r, lat);
      check(VEC[i].tag, r, VEC[i].exp);
    end

    // R8 one-cycle latency and single pulse
    run_op(4'h0, 1'b1, 1'b1, 32'h0, 64'd3, 64'd4, r, lat);
    check("R8 ", 64'(lat), 64'd1);
    check("R8 ", r, 64'd7);
    @(negedge clk_i);
    check("R8 ", {63'b0, done_o}, 64'h0);

    // R9 division latency
    run_op(4'h3, 1'b1, 1'b1, 32'h0, 64'd1000, 64'd10, r, lat);
    check("R9 ", 64'(lat), 64'(XLEN + 1));
    check("R9 ", r, 64'd100);

    // R9 / R10: busy held, starts during busy ignored
    @(negedge clk_i);
    op_i = 4'h9; wide_i = 1'b1; src_sel_i = 1'b1; dst_i = 64'd1000; src_i = 64'd17;
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R9 ", {63'b0, busy_o}, 64'h1);
    op_i = 4'h0; dst_i = 64'd1; src_i = 64'd1;
    start_i = 1'b1;
    cyc = 1;
    ndone = 0;
    r = '0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk_i);
      cyc++;
      @(negedge clk_i);
      if (cyc > 4) start_i = 1'b0;
      if (done_o) begin
        ndone++;
        r = result_o;
        break;
      end
    end
    start_i = 1'b0;
    check("R10", 64'(cyc), 64'(XLEN + 1));
    check("R10", r, 64'd14);
    @(negedge clk_i);
    check("R10", {63'b0, done_o}, 64'h0);
    check("R10", 64'(ndone), 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule